// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block runs one burst of 8-bit words on a single-lane SPI bus as the master. A 32-bit control word, written by the surrounding logic, selects clock polarity and phase, bit order, which of four chip-select lines is used and how it is driven, and whether received bytes are kept. Setting the start bit launches the burst. The start bit reads back as 1 while the burst runs and clears itself when the burst ends.

Two 24-bit counts shape the burst. The total count is the number of bytes clocked on the wire. The transmit count is the number of those bytes taken from an external TX FIFO. The leading bytes come from the FIFO, and every byte after them is a dummy byte sent with MOSI held low. Each byte clocked in from MISO is pushed into an RX FIFO unless receive discard is set. SCK advances only on a one-cycle tick from an external divider, at one half period per tick. If the FIFO runs dry during the transmit part, the engine waits with SCK idle until a byte arrives.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, SCK is low, all chip selects are low, the control word reads 0 and xfer_done, tx_pop and rx_push are low.
- R2: Writing a control word with bit 31 set starts a burst. Bit 31 reads back as 1 until the burst ends, and it reads 0 in the cycle in which xfer_done is high.
- R3: A burst shifts exactly burst_len bytes, which is 16 SCK edges per byte, and then raises xfer_done for a single cycle. When burst_len is 0, xfer_done is raised with no SCK edges.
- R4: The first tx_len bytes on MOSI are popped from the TX FIFO in order. The remaining burst_len - tx_len bytes are sent as 0x00.
- R5: SCK idles at CPOL (control bit 1). With CPHA (bit 0) clear, data is sampled on the first edge of each bit. With CPHA set, data is sampled on the second edge.
- R6: Bit 12 clear sends and receives the MSB first. Bit 12 set sends and receives the LSB first.
- R7: Every byte captured from MISO is pushed to rx_data with rx_push in its bit-order position. With discard (bit 8) set, no push occurs.
- R8: Bits 5:4 select one chip-select line. Bit 2 sets the idle level of every line. In manual mode (bit 6), the selected line takes the level in bit 7. In automatic mode, the selected line takes the inverse of the idle level during a burst.
- R9: While bus_en is low, SCK does not move and a pending start does not begin. The burst proceeds once bus_en is raised.
- R10: If the TX FIFO is empty while FIFO bytes are still owed, the engine stalls with SCK at its idle level and never pops an empty FIFO. It resumes when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus enable; SCK is frozen while low |
| sck_tick | input | 1 | One-cycle pulse, one per SCK half period |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback, bit 31 = burst running |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Bytes taken from the TX FIFO |
| tx_empty | input | 1 | TX FIFO empty |
| tx_data | input | 8 | TX FIFO head byte |
| tx_pop | output | 1 | Pop TX FIFO head |
| rx_push | output | 1 | Push rx_data to the RX FIFO |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| cs | output | 4 | Chip-select lines |
| xfer_done | output | 1 | Transfer complete pulse |

## Verification
The final SCK edge of a burst completes the last received byte and also finishes the burst. In the same cycle, the engine pushes that byte, pulses xfer_done and clears the start bit. With CPHA set, the last MISO bit is captured on that same edge. The stimulus covers both phases with MISO looped back inverted from MOSI. The check confirms that the RX stream holds every byte, including the final one, with the correct value. It also confirms that the start bit reads 0 in the very cycle xfer_done is seen and that exactly one completion pulse occurs.

// File: rtl/spi_burst_pkg.sv
// Package: control word field positions, decoded settings and the engine states.
// Assumes a 32-bit control word and 8-bit SPI words.
package spi_burst_pkg;
    localparam int CW_W       = 32;
    localparam int CW_CPHA    = 0;
    localparam int CW_CPOL    = 1;
    localparam int CW_CSIDLE  = 2;
    localparam int CW_CSSEL   = 4;   // two bits, 5:4
    localparam int CW_CSMAN   = 6;
    localparam int CW_CSLVL   = 7;
    localparam int CW_DROP    = 8;
    localparam int CW_LSB     = 12;
    localparam int CW_GO      = 31;
    localparam int SEL_W      = 2;

    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             cs_idle_high;
        logic [SEL_W-1:0] cs_sel;
        logic             cs_manual;
        logic             cs_level;
        logic             drop_rx;
        logic             lsb_first;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_ctl_word.sv
// Control word register. It holds the configuration fields and a start bit
// that is set by a write and cleared by the engine's finish pulse.
// Assumes that finish takes priority over a simultaneous start write.
module spi_ctl_word
    import spi_burst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW_W-1:0] wr_data,
    input  logic            finish,
    output xfer_cfg_t       cfg,
    output logic            go,
    output logic [CW_W-1:0] rdata
);
    localparam logic [CW_W-1:0] KEEP_MASK =
        (CW_W'(1) << CW_CPHA) | (CW_W'(1) << CW_CPOL) | (CW_W'(1) << CW_CSIDLE) |
        (CW_W'(3) << CW_CSSEL) | (CW_W'(1) << CW_CSMAN) | (CW_W'(1) << CW_CSLVL) |
        (CW_W'(1) << CW_DROP) | (CW_W'(1) << CW_LSB);

    logic [CW_W-1:0] word_q;

    // Store configuration bits and track the self-clearing start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            go     <= 1'b0;
        end else begin
            if (wr_en) word_q <= wr_data & KEEP_MASK;
            if (finish)                        go <= 1'b0;
            else if (wr_en && wr_data[CW_GO])  go <= 1'b1;
        end
    end

    // Decode fields and form the readback value.
    always_comb begin
        cfg.cpha         = word_q[CW_CPHA];
        cfg.cpol         = word_q[CW_CPOL];
        cfg.cs_idle_high = word_q[CW_CSIDLE];
        cfg.cs_sel       = word_q[CW_CSSEL +: SEL_W];
        cfg.cs_manual    = word_q[CW_CSMAN];
        cfg.cs_level     = word_q[CW_CSLVL];
        cfg.drop_rx      = word_q[CW_DROP];
        cfg.lsb_first    = word_q[CW_LSB];
        rdata            = word_q;
        rdata[CW_GO]     = go;
    end

    p_go_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !go);
    p_go_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !finish) |=> go);
endmodule

// File: rtl/spi_shift_core.sv
// Burst sequencer and shifter. It fetches a FIFO byte or a dummy zero byte,
// shifts it over two ticks per bit, captures MISO and counts bytes to the end.
// Assumes DATA_W is a power of two and sck_tick is a single-cycle pulse.
module spi_shift_core
    import spi_burst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              tick,
    input  logic              go,
    input  xfer_cfg_t         cfg,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              finish,
    output logic              done,
    output logic              active
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    eng_state_t        st;
    logic [CNT_W-1:0]  sent;
    logic [IDX_W-1:0]  bit_idx;
    logic              half, sck_act;
    logic [DATA_W-1:0] tx_sh, rx_sh, rx_with, rx_cur, fetch_byte;
    logic              tick_en, lead, trail, sample, byte_end, is_last;
    logic              need_tx, fetch_go, start_ok;
    logic [CNT_W-1:0]  sent_inc;

    // Map a bit counter onto a byte position for the selected bit order.
    function automatic logic [IDX_W-1:0] pos(input logic [IDX_W-1:0] idx, input logic lsb);
        return lsb ? idx : LAST_IDX - idx;
    endfunction

    // Edge classification, byte accounting and FIFO handshake.
    always_comb begin
        tick_en    = tick && bus_en;
        lead       = (st == ST_SHIFT) && tick_en && !half;
        trail      = (st == ST_SHIFT) && tick_en && half;
        sample     = cfg.cpha ? trail : lead;
        rx_with    = rx_sh;
        rx_with[pos(bit_idx, cfg.lsb_first)] = miso;
        rx_cur     = sample ? rx_with : rx_sh;
        byte_end   = trail && (bit_idx == LAST_IDX);
        sent_inc   = sent + 1'b1;
        is_last    = (sent_inc == burst_len);
        need_tx    = (sent < tx_len);
        fetch_byte = need_tx ? tx_data : '0;
        fetch_go   = (st == ST_FETCH) && bus_en && (!need_tx || !tx_empty);
        tx_pop     = (st == ST_FETCH) && bus_en && need_tx && !tx_empty;
        start_ok   = (st == ST_IDLE) && go && bus_en;
        finish     = (start_ok && (burst_len == '0)) || (byte_end && is_last);
        sck        = cfg.cpol ^ sck_act;
        active     = (st != ST_IDLE);
    end

    // Burst state machine with shift, capture and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            sent    <= '0;
            bit_idx <= '0;
            half    <= 1'b0;
            sck_act <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            mosi    <= 1'b0;
            rx_push <= 1'b0;
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            done    <= finish;
            case (st)
                ST_IDLE: if (start_ok) begin
                    sent <= '0;
                    if (burst_len != '0) st <= ST_FETCH;
                end
                ST_FETCH: if (fetch_go) begin
                    tx_sh   <= fetch_byte;
                    mosi    <= fetch_byte[pos('0, cfg.lsb_first)];
                    bit_idx <= '0;
                    half    <= 1'b0;
                    rx_sh   <= '0;
                    st      <= ST_SHIFT;
                end
                ST_SHIFT: if (tick_en) begin
                    half    <= !half;
                    sck_act <= !half;
                    if (sample) rx_sh <= rx_with;
                    if (lead && cfg.cpha) mosi <= tx_sh[pos(bit_idx, cfg.lsb_first)];
                    if (trail) begin
                        bit_idx <= bit_idx + 1'b1;
                        if (!cfg.cpha && bit_idx != LAST_IDX)
                            mosi <= tx_sh[pos(bit_idx + 1'b1, cfg.lsb_first)];
                        if (byte_end) begin
                            sent    <= sent_inc;
                            rx_data <= rx_cur;
                            rx_push <= !cfg.drop_rx;
                            st      <= is_last ? ST_IDLE : ST_FETCH;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_pop_not_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    p_sck_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en && $past(!bus_en)) |-> $stable(sck_act));
    p_no_push_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(cfg.drop_rx));
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_stall_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |-> !sck_act);
endmodule

// File: rtl/spi_cs_drive.sv
// Chip-select drivers. Unselected lines rest at the idle level. The selected
// line follows either the manual level or the burst activity.
// Assumes that the select field addresses NUM_CS lines or fewer.
module spi_cs_drive
    import spi_burst_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_cfg_t         cfg,
    input  logic              active,
    output logic [NUM_CS-1:0] cs
);
    logic sel_level;

    // Level of the selected line for the current mode.
    always_comb begin
        if (cfg.cs_manual) sel_level = cfg.cs_level;
        else               sel_level = active ? !cfg.cs_idle_high : cfg.cs_idle_high;
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs[g] = (32'(cfg.cs_sel) == g) ? sel_level : cfg.cs_idle_high;
    end

    p_cs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs ^ {NUM_CS{cfg.cs_idle_high}}) <= 1);
endmodule

// File: rtl/spi_burst_engine.sv
// Top level of the SPI master burst engine. It joins the control word, the
// shift core and the chip-select drivers. Assumes external FIFOs and an
// external SCK tick divider.
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 24,
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              sck_tick,
    input  logic              ctrl_we,
    input  logic [CW_W-1:0]   ctrl_wdata,
    output logic [CW_W-1:0]   ctrl_rdata,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs,
    output logic              xfer_done
);
    xfer_cfg_t cfg;
    logic      go, finish, active;

    spi_ctl_word u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wr_data(ctrl_wdata),
        .finish(finish), .cfg(cfg), .go(go), .rdata(ctrl_rdata)
    );

    spi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .tick(sck_tick), .go(go),
        .cfg(cfg), .burst_len(burst_len), .tx_len(tx_len), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .miso(miso), .sck(sck), .mosi(mosi),
        .rx_push(rx_push), .rx_data(rx_data), .finish(finish), .done(xfer_done),
        .active(active)
    );

    spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .active(active), .cs(cs)
    );

    p_done_go_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !ctrl_rdata[CW_GO]);
endmodule

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        sck_tick = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [23:0] burst_len = '0;
    logic [23:0] tx_len = '0;
    logic        tx_empty;
    logic [7:0]  tx_data;
    logic        tx_pop, rx_push, sck, mosi, miso, xfer_done;
    logic [7:0]  rx_data;
    logic [3:0]  cs;

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    logic [7:0] mem [64];
    int pop_cnt = 0, base = 0, avail = 0, tick_per = 2;
    bit finished = 0;

    assign tx_empty = (pop_cnt - base) >= avail;
    assign tx_data  = mem[6'(pop_cnt - base)];
    assign miso     = ~mosi;

    spi_burst_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .sck_tick(sck_tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .burst_len(burst_len), .tx_len(tx_len), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs(cs), .xfer_done(xfer_done)
    );

    // TX FIFO model: count pops at the clock edge.
    always @(posedge clk) if (tx_pop) pop_cnt <= pop_cnt + 1;

    // Tick divider model.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = c + 1;
            if (c >= tick_per) begin sck_tick = 1'b1; c = 0; end
            else sck_tick = 1'b0;
        end
    end

    // Bus monitor.
    bit m_cpol, m_cpha, m_lsb, mon_rst;
    int edges, ncap, nbits, nrx, ndone, go_at_done;
    logic [7:0] cap [64];
    logic [7:0] rxg [64];
    logic [7:0] mb;
    logic [3:0] cs_seen;
    logic prev_sck;
    initial begin
        forever begin
            @(negedge clk);
            if (mon_rst) begin
                edges = 0; ncap = 0; nbits = 0; nrx = 0; ndone = 0;
                go_at_done = 0; prev_sck = sck; mb = 0; cs_seen = 'x;
            end else if (rst_n) begin
                if (sck !== prev_sck) begin
                    edges++;
                    if ((m_cpha ? (sck == m_cpol) : (sck != m_cpol))) begin
                        if (m_lsb) mb = {mosi, mb[7:1]};
                        else       mb = {mb[6:0], mosi};
                        nbits++;
                        if (ncap == 0 && nbits == 1) cs_seen = cs;
                        if (nbits == 8) begin
                            if (ncap < 64) cap[ncap] = mb;
                            ncap++; nbits = 0;
                        end
                    end
                end
                prev_sck = sck;
                if (rx_push) begin
                    if (nrx < 64) rxg[nrx] = rx_data;
                    nrx++;
                end
                if (xfer_done) begin
                    ndone++;
                    go_at_done = ctrl_rdata[31];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input int txn);
        return (i < txn) ? mem[i] : 8'h00;
    endfunction

    function automatic logic [3:0] exp_cs(input bit man, input bit lvl, input bit idh,
                                          input int sel, input bit act);
        logic [3:0] v = {4{idh}};
        v[sel] = man ? lvl : (act ? !idh : idh);
        return v;
    endfunction

    task automatic run_burst(input bit cpol, input bit cpha, input bit lsb, input bit drop,
                             input bit man, input bit lvl, input bit idh, input int sel,
                             input int tot, input int txn, input int per,
                             input int hold, input bit gate);
        logic [31:0] w;
        int wait_c, bad_tx, bad_rx, first;
        @(negedge clk);
        for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
        base = pop_cnt;
        avail = (hold >= 0) ? hold : txn;
        tick_per = per;
        burst_len = 24'(tot);
        tx_len = 24'(txn);
        w = '0;
        w[0] = cpha; w[1] = cpol; w[2] = idh; w[5:4] = 2'(sel);
        w[6] = man; w[7] = lvl; w[8] = drop; w[12] = lsb;
        ctrl_we = 1'b1; ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
        bus_en = !gate;
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; mon_rst = 1'b1;
        @(negedge clk);
        mon_rst = 1'b0;
        check(sck == cpol, "R5", "idle sck", sck, cpol);
        ctrl_we = 1'b1; ctrl_wdata = w | 32'h8000_0000;
        @(negedge clk);
        ctrl_we = 1'b0;
        if (tot > 0)
            check(ctrl_rdata[31] == 1'b1, "R2", "start readback", ctrl_rdata[31], 1);
        if (gate) begin
            repeat (60) @(negedge clk);
            check(edges == 0 && ndone == 0 && ctrl_rdata[31] == 1'b1 && sck == cpol,
                  "R9", "bus disabled hold", edges, 0);
            bus_en = 1'b1;
        end
        if (hold >= 0) begin
            repeat (40 * per * 20) @(negedge clk);
            check((pop_cnt - base) == hold && ndone == 0 && sck == cpol && edges == 16 * hold,
                  "R10", "stall on empty fifo", edges, 16 * hold);
            avail = txn;
        end
        wait_c = 0;
        while (ndone == 0 && wait_c < 20000) begin @(negedge clk); wait_c++; end
        repeat (10) @(negedge clk);
        check(ndone == 1, "R3", "done pulses", ndone, 1);
        check(go_at_done == 0 && ctrl_rdata[31] == 1'b0, "R2", "start cleared at done",
              go_at_done, 0);
        check(edges == 16 * tot, "R3", "sck edges", edges, 16 * tot);
        check(ncap == tot, "R3", "bytes on wire", ncap, tot);
        check((pop_cnt - base) == txn, "R4", "fifo pops", pop_cnt - base, txn);
        bad_tx = 0; first = -1;
        for (int i = 0; i < tot && i < 64; i++)
            if (cap[i] !== exp_byte(i, txn)) begin bad_tx++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        check(bad_tx == 0, (cpha ? "R5/R6 R4" : "R4 R6"), "mosi stream",
              cap[first], exp_byte(first, txn));
        check(nrx == (drop ? 0 : tot), "R7", "rx push count", nrx, drop ? 0 : tot);
        bad_rx = 0; first = -1;
        if (!drop)
            for (int i = 0; i < tot && i < 64; i++)
                if (rxg[i] !== ~exp_byte(i, txn)) begin bad_rx++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        check(bad_rx == 0, "R7", "rx data", rxg[first], ~exp_byte(first, txn));
        if (tot > 0)
            check(cs_seen === exp_cs(man, lvl, idh, sel, 1), "R8", "cs during burst",
                  cs_seen, exp_cs(man, lvl, idh, sel, 1));
        check(cs === exp_cs(man, lvl, idh, sel, 0), "R8", "cs after burst",
              cs, exp_cs(man, lvl, idh, sel, 0));
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mon_rst = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck == 1'b0 && cs == 4'b0 && ctrl_rdata == 32'h0 && !xfer_done && !tx_pop && !rx_push,
              "R1", "reset state", {ctrl_rdata, cs, sck}, 0);
        // Directed corners.
        run_burst(0, 0, 0, 0, 1, 1, 0, 2, 5, 5, 1, -1, 0);   // all from fifo, manual cs
        run_burst(1, 1, 1, 0, 0, 0, 1, 3, 4, 1, 2, -1, 0);   // dummy tail, auto cs
        run_burst(0, 1, 0, 1, 1, 0, 1, 0, 6, 0, 3, -1, 0);   // all dummy, discard
        run_burst(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, -1, 0);   // zero-length burst
        run_burst(0, 0, 1, 0, 0, 0, 1, 2, 6, 6, 2, 2, 0);    // stall on empty fifo
        run_burst(1, 1, 0, 0, 1, 1, 1, 1, 3, 2, 1, -1, 1);   // bus enable gating
        // Random mix.
        for (int k = 0; k < 10; k++) begin
            int t = 1 + int'($urandom_range(0, 23));
            run_burst(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                      t, int'($urandom_range(0, t)), 1 + int'($urandom_range(0, 3)), -1, 0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule